// File: doc/BRIEF.md
# Default Data-Access Protection Checker

This block sits beside a dual-port load/store unit and checks every data access while the page-based protection tables are switched off. Each port presents a valid strobe, a byte address and a read/write flag. One mode input says whether the processor runs in user or supervisor mode. The checker uses no lookup tables. It decodes one fixed region at the top of the address space, which holds the memory-mapped registers, and applies two rules to it:

- In user mode, an access to the region from either port is refused.
- An access to the region from port 1 is refused even in supervisor mode.

A refused access never reaches memory, because its memory enable is held low in the same cycle. One clock later the checker raises a one-cycle exception request that carries a fixed cause code. At the same edge it captures the offending address and a three-bit status word in two registers that software can read. Port 0 wins when both ports are refused together.

Top module: `dprot_guard`

## Requirements
- R1: After synchronous reset, `exc_req` is 0, `exc_cause` is 0, `fault_addr` is 0 and `fault_status` is 0.
- R2: A valid user-mode access from either port to an address at or above `MMR_BASE` (default 0xFFC00000) makes `exc_req` high in the cycle after the access.
- R3: A valid supervisor-mode access from port 1 to the region also makes `exc_req` high in the next cycle.
- R4: Some accesses never fault: a supervisor-mode access from port 0 to the region, and any access below `MMR_BASE` in either mode.
- R5: `exc_cause` equals 0x23 in every cycle that `exc_req` is high, and 0 otherwise.
- R6: On a fault, `fault_addr` takes the full byte address of the refused access.
- R7: On a fault, `fault_status` bit 0 is 1 for a write and 0 for a read. Bit 1 is 1 for port 1 and 0 for port 0. Bit 2 is 1 for supervisor mode and 0 for user mode. All higher bits are 0.
- R8: When both ports fault in the same cycle, one `exc_req` pulse is issued and the address and status of port 0 are captured.
- R9: `fault_addr` and `fault_status` keep their values until the next fault overwrites them. Faults in consecutive cycles each overwrite them.
- R10: The memory enable of a port is the same cycle's valid strobe, except that it is forced low when that access faults.
- R11: `exc_req` is high for exactly one cycle for each faulting cycle. An access with its valid strobe low has no effect, whatever its address.
- R12: The port 0 decision does not depend on any traffic on port 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| p0_valid | input | 1 | Port 0 access strobe |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_write | input | 1 | Port 0 direction, 1 = write |
| p1_valid | input | 1 | Port 1 access strobe |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_write | input | 1 | Port 1 direction, 1 = write |
| p0_mem_en | output | 1 | Port 0 enable toward memory |
| p1_mem_en | output | 1 | Port 1 enable toward memory |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | CAUSE_W | Cause code while `exc_req` is high |
| fault_addr | output | ADDR_W | Captured address of the last fault |
| fault_status | output | STAT_W | Captured status of the last fault |

## Verification
The bench builds the block with its default parameters: a 32-bit address, `MMR_BASE` at 0xFFC00000, a 32-bit status word and an 8-bit cause field. With these values the region's first byte sits right next to the last byte that passes (0xFFBFFFFF), and the top of the address space (0xFFFFFFFC) is also reachable. Both can be driven as direct boundary cases. The 32-bit status width also lets the bench confirm that every bit above bit 2 stays zero.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

    localparam int unsigned NPORT = 2;

    // Captured fault record; packed order gives status bit2..bit0.
    typedef struct packed {
        logic supervisor;
        logic port1;
        logic write;
    } flt_info_t;

    localparam int unsigned INFO_W = $bits(flt_info_t);

    function automatic flt_info_t make_info(input logic wr, input logic port1,
                                            input logic supervisor);
        flt_info_t f;
        f.supervisor = supervisor;
        f.port1      = port1;
        f.write      = wr;
        return f;
    endfunction

endpackage

// File: rtl/dprot_port_rule.sv
module dprot_port_rule
    import dprot_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MMR_BASE = 32'hFFC0_0000,
    parameter int unsigned PORT_IDX = 0
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              user_mode,
    output logic              viol,
    output logic              mem_en,
    output flt_info_t         info
);
    logic in_window;
    logic mode_blocked;

    assign in_window = (addr >= MMR_BASE);

    // Port 0 is refused only in user mode; every other port is refused in any mode.
    generate
        if (PORT_IDX == 0) begin : g_mode_checked
            assign mode_blocked = user_mode;
        end else begin : g_always_blocked
            assign mode_blocked = 1'b1;
        end
    endgenerate

    assign viol   = valid && in_window && mode_blocked;
    assign mem_en = valid && !viol;
    assign info   = make_info(write, (PORT_IDX != 0), !user_mode);
endmodule

// File: rtl/dprot_select.sv
module dprot_select
    import dprot_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [NPORT-1:0]             viol,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  flt_info_t [NPORT-1:0]        info,
    output logic                         any_viol,
    output logic [ADDR_W-1:0]            sel_addr,
    output flt_info_t                    sel_info
);
    // Lowest port index wins: scan from the top so the lowest writes last.
    always_comb begin
        sel_addr = '0;
        sel_info = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (viol[i]) begin
                sel_addr = addr[i];
                sel_info = info[i];
            end
        end
    end

    assign any_viol = |viol;
endmodule

// File: rtl/dprot_capture.sv
module dprot_capture
    import dprot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned CAUSE_W = 8,
    parameter logic [CAUSE_W-1:0] CAUSE = 8'h23
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               any_viol,
    input  logic [ADDR_W-1:0]  sel_addr,
    input  flt_info_t          sel_info,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [ADDR_W-1:0]  fault_addr,
    output logic [STAT_W-1:0]  fault_status
);
    localparam int unsigned PAD_W = STAT_W - INFO_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_req      <= 1'b0;
            exc_cause    <= '0;
            fault_addr   <= '0;
            fault_status <= '0;
        end else begin
            exc_req   <= any_viol;
            exc_cause <= any_viol ? CAUSE : '0;
            if (any_viol) begin
                fault_addr   <= sel_addr;
                fault_status <= {{PAD_W{1'b0}}, sel_info};
            end
        end
    end

    p_cause_r5: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (exc_cause == CAUSE));
    p_idle_cause_r5: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> (exc_cause == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(any_viol) |-> ($stable(fault_addr) && $stable(fault_status)));
    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(fault_status[STAT_W-1:INFO_W]) == 0);
    p_only_on_fault_r11: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> $past(any_viol));
endmodule

// File: rtl/dprot_guard.sv
module dprot_guard
    import dprot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] MMR_BASE = 32'hFFC0_0000,
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned CAUSE_W = 8,
    parameter logic [CAUSE_W-1:0] CAUSE = 8'h23
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               user_mode,
    input  logic               p0_valid,
    input  logic [ADDR_W-1:0]  p0_addr,
    input  logic               p0_write,
    input  logic               p1_valid,
    input  logic [ADDR_W-1:0]  p1_addr,
    input  logic               p1_write,
    output logic               p0_mem_en,
    output logic               p1_mem_en,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [ADDR_W-1:0]  fault_addr,
    output logic [STAT_W-1:0]  fault_status
);
    logic [NPORT-1:0]             valid_v;
    logic [NPORT-1:0]             write_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0]             viol_v;
    logic [NPORT-1:0]             en_v;
    flt_info_t [NPORT-1:0]        info_v;
    logic                         any_viol;
    logic [ADDR_W-1:0]            sel_addr;
    flt_info_t                    sel_info;

    assign valid_v = {p1_valid, p0_valid};
    assign write_v = {p1_write, p0_write};
    assign addr_v  = {p1_addr, p0_addr};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            dprot_port_rule #(
                .ADDR_W  (ADDR_W),
                .MMR_BASE(MMR_BASE),
                .PORT_IDX(g)
            ) u_rule (
                .valid    (valid_v[g]),
                .addr     (addr_v[g]),
                .write    (write_v[g]),
                .user_mode(user_mode),
                .viol     (viol_v[g]),
                .mem_en   (en_v[g]),
                .info     (info_v[g])
            );
        end
    endgenerate

    assign p0_mem_en = en_v[0];
    assign p1_mem_en = en_v[1];

    dprot_select #(.ADDR_W(ADDR_W)) u_select (
        .viol    (viol_v),
        .addr    (addr_v),
        .info    (info_v),
        .any_viol(any_viol),
        .sel_addr(sel_addr),
        .sel_info(sel_info)
    );

    dprot_capture #(
        .ADDR_W (ADDR_W),
        .STAT_W (STAT_W),
        .CAUSE_W(CAUSE_W),
        .CAUSE  (CAUSE)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .any_viol    (any_viol),
        .sel_addr    (sel_addr),
        .sel_info    (sel_info),
        .exc_req     (exc_req),
        .exc_cause   (exc_cause),
        .fault_addr  (fault_addr),
        .fault_status(fault_status)
    );

    p_user_fault_r2: assert property (@(posedge clk) disable iff (rst)
        (p1_valid && user_mode && p1_addr >= MMR_BASE) |=> exc_req);
    p_port1_sup_r3: assert property (@(posedge clk) disable iff (rst)
        (p1_valid && !user_mode && p1_addr >= MMR_BASE) |=>
            (exc_req && fault_status[1] == $past(!p0_valid || !user_mode || p0_addr < MMR_BASE)));
    p_low_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_addr < MMR_BASE) |-> p0_mem_en);
    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (p1_valid && p1_addr >= MMR_BASE) |-> !p1_mem_en);
    p_prio_r8: assert property (@(posedge clk) disable iff (rst)
        (viol_v[0] && viol_v[1]) |=>
            (!fault_status[1] && fault_addr == $past(p0_addr)));
endmodule

// File: tb/dprot_guard_test.sv
`timescale 1ns/100ps
module dprot_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        user_mode = 1'b1;
    logic        p0_valid = 1'b0, p0_write = 1'b0;
    logic        p1_valid = 1'b0, p1_write = 1'b0;
    logic [31:0] p0_addr = '0, p1_addr = '0;
    logic        p0_mem_en, p1_mem_en, exc_req;
    logic [7:0]  exc_cause;
    logic [31:0] fault_addr, fault_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dprot_guard uut (
        .clk(clk), .rst(rst), .user_mode(user_mode),
        .p0_valid(p0_valid), .p0_addr(p0_addr), .p0_write(p0_write),
        .p1_valid(p1_valid), .p1_addr(p1_addr), .p1_write(p1_write),
        .p0_mem_en(p0_mem_en), .p1_mem_en(p1_mem_en),
        .exc_req(exc_req), .exc_cause(exc_cause),
        .fault_addr(fault_addr), .fault_status(fault_status)
    );

    function automatic logic [31:0] stat(input logic wr, input logic port1, input logic sup);
        return {29'd0, sup, port1, wr};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v0, input logic [31:0] a0, input logic w0,
                         input logic v1, input logic [31:0] a1, input logic w1,
                         input logic usr);
        p0_valid = v0; p0_addr = a0; p0_write = w0;
        p1_valid = v1; p1_addr = a1; p1_write = w1;
        user_mode = usr;
    endtask

    task automatic idle();
        p0_valid = 1'b0; p1_valid = 1'b0;
    endtask

    // Fault expected: check enables now, results one edge later, pulse gone after that.
    task automatic expect_fault(input string req, input logic [31:0] ea,
                                input logic [31:0] es);
        @(negedge clk); idle();
        check({req, " exc_req"}, exc_req, 1);
        check("R5 cause", exc_cause, 32'h23);
        check("R6 fault_addr", fault_addr, ea);
        check("R7 fault_status", fault_status, es);
        @(negedge clk);
        check("R11 single pulse", exc_req, 0);
        check("R5 cause idle", exc_cause, 0);
    endtask

    task automatic t_reset();
        check("R1 exc_req", exc_req, 0);
        check("R1 exc_cause", exc_cause, 0);
        check("R1 fault_addr", fault_addr, 0);
        check("R1 fault_status", fault_status, 0);
    endtask

    task automatic t_user_p0_write();
        @(negedge clk); drive(1, 32'hFFC0_0000, 1, 0, 0, 0, 1);
        #1 check("R10 p0 blocked", p0_mem_en, 0);
        expect_fault("R2", 32'hFFC0_0000, stat(1, 0, 0));
    endtask

    task automatic t_user_p1_read();
        @(negedge clk); drive(0, 0, 0, 1, 32'hFFE0_1004, 0, 1);
        #1 check("R10 p1 blocked", p1_mem_en, 0);
        expect_fault("R2", 32'hFFE0_1004, stat(0, 1, 0));
    endtask

    task automatic t_sup_p1_write();
        @(negedge clk); drive(0, 0, 0, 1, 32'hFFFF_FFFC, 1, 0);
        #1 check("R10 p1 sup blocked", p1_mem_en, 0);
        expect_fault("R3", 32'hFFFF_FFFC, stat(1, 1, 1));
    endtask

    task automatic t_passing();
        @(negedge clk); drive(1, 32'hFFC0_0000, 0, 1, 32'hFFBF_FFFF, 1, 0);
        #1 check("R4 p0 sup pass", p0_mem_en, 1);
        check("R4 p1 below base", p1_mem_en, 1);
        @(negedge clk); drive(1, 32'hFFBF_FFFF, 1, 1, 32'h0000_1000, 0, 1);
        check("R4 no fault", exc_req, 0);
        #1 check("R10 user low p0", p0_mem_en, 1);
        @(negedge clk); idle();
        check("R4 no fault user low", exc_req, 0);
        check("R9 addr held", fault_addr, 32'hFFFF_FFFC);
        check("R9 status held", fault_status, stat(1, 1, 1));
    endtask

    task automatic t_invalid();
        @(negedge clk); drive(0, 32'hFFC0_0010, 1, 0, 32'hFFC0_0020, 0, 1);
        #1 check("R11 invalid p0 en", p0_mem_en, 0);
        @(negedge clk);
        check("R11 invalid no fault", exc_req, 0);
        check("R11 addr unchanged", fault_addr, 32'hFFFF_FFFC);
    endtask

    task automatic t_both();
        @(negedge clk); drive(1, 32'hFFC0_0100, 0, 1, 32'hFFD0_0200, 1, 1);
        expect_fault("R8", 32'hFFC0_0100, stat(0, 0, 0));
    endtask

    task automatic t_concurrent();
        @(negedge clk); drive(1, 32'hFFC0_0040, 1, 1, 32'h2000_0000, 1, 1);
        #1 check("R12 p1 harmless en", p1_mem_en, 1);
        check("R12 p0 blocked", p0_mem_en, 0);
        expect_fault("R12", 32'hFFC0_0040, stat(1, 0, 0));
    endtask

    task automatic t_back_to_back();
        @(negedge clk); drive(1, 32'hFFC0_0004, 0, 0, 0, 0, 1);
        @(negedge clk); drive(0, 0, 0, 1, 32'hFFC0_0008, 1, 0);
        check("R9 first exc", exc_req, 1);
        check("R9 first addr", fault_addr, 32'hFFC0_0004);
        @(negedge clk); idle();
        check("R11 second pulse", exc_req, 1);
        check("R9 second addr", fault_addr, 32'hFFC0_0008);
        check("R9 second status", fault_status, stat(1, 1, 1));
        @(negedge clk);
        check("R11 pulse ends", exc_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_user_p0_write();
        t_user_p1_read();
        t_sup_p1_write();
        t_passing();
        t_invalid();
        t_both();
        t_concurrent();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule